// File: doc/BRIEF.md
# Reed-Solomon Parity Generator for Flash Page Packets

This block computes the check symbols of a systematic Reed-Solomon code over GF(2^10) for one flash page packet. Data arrives one byte per valid/ready handshake. Each byte becomes a 10-bit field symbol with its two upper bits at zero. After the final byte of the packet, the block holds eight parity symbols. A decoder can use the resulting 520-symbol codeword to repair up to four damaged symbols.

The parity symbols come out one per cycle on a symbol port, the highest-order symbol first. The same 80 bits also stay on a wide port, arranged for the page spare area as ten bytes. A single-cycle done flag marks the first parity cycle. A start pulse clears the divider state and the byte count at any time, so the next packet is encoded on its own.

Top module: `rs_ecc_enc`

## Requirements
- R1: An input byte b enters the divider as the symbol {2'b00, b}. Field arithmetic is modulo x^10 + x^3 + 1, and alpha is the symbol 10'h002.
- R2: After PKT_LEN accepted bytes, the parity equals the remainder of d(x)*x^8 divided by g(x) = (x+alpha^0)(x+alpha^1)...(x+alpha^7). The first accepted byte is the coefficient of the highest power of d(x).
- R3: The codeword made of the data symbols followed by the parity symbols, highest order first, has zero syndromes at alpha^0 through alpha^7.
- R4: par_valid_o is high for exactly NPAR consecutive cycles. These begin in the cycle after the last byte is accepted. par_sym_o carries parity word 0 (the highest-order remainder coefficient) first, then words 1 to 7 in order.
- R5: done_o is high for exactly one cycle, which is the first cycle of par_valid_o.
- R6: par_bytes_o = {word0, word1, ..., word7}. Spare byte k is par_bytes_o[79-8k -: 8]. The value holds steady while data_ready_o is low and start_i is low.
- R7: data_ready_o is high from reset or start until the last byte of a packet is accepted. It then stays low until the next start. Bytes offered while it is low are not taken, and they change neither the parity nor the outputs.
- R8: A start_i pulse in any state clears the parity to zero and restarts the byte count. A packet sent after a start that came mid-packet gives the parity of that packet alone.
- R9: start_i takes priority over a byte offered in the same cycle: data_ready_o is low in that cycle and the byte is not taken.
- R10: After reset, data_ready_o is 1, while par_valid_o, done_o and par_bytes_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear pulse that begins a new packet |
| data_valid_i | input | 1 | A data byte is offered |
| data_i | input | DATA_W | Data byte |
| data_ready_o | output | 1 | The offered byte is taken this cycle |
| par_valid_o | output | 1 | par_sym_o carries a parity symbol |
| par_sym_o | output | SYM_W | Parity symbol, word 0 first |
| done_o | output | 1 | One-cycle flag: the parity is complete |
| par_bytes_o | output | NPAR*SYM_W | Packed parity for the spare area, byte 0 in the top bits |

## Verification
The bench builds the block with its default parameters: 512-byte packets, 10-bit symbols, 8 parity symbols and the x^10 + x^3 + 1 field. At these values every full packet is a real 520-symbol codeword. Each codeword can therefore be compared against a long-division reference and checked for zero syndromes at all eight generator roots. With the full packet length, a restart after 100 bytes and rejected offers during the hold phase can both be observed before a clean packet follows.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;

  typedef enum logic [1:0] {
    ST_ACCEPT = 2'd0,
    ST_EMIT   = 2'd1,
    ST_HOLD   = 2'd2
  } enc_state_e;

  // GF(2^w) multiply, w <= 15, poly holds the low w bits of the field polynomial
  function automatic logic [15:0] gf_mul_w(logic [15:0] a, logic [15:0] b, int w, logic [15:0] poly);
    logic [15:0] r;
    logic [15:0] full;
    r    = '0;
    full = poly | (16'd1 << w);
    for (int i = 15; i >= 0; i--) begin
      r = {r[14:0], 1'b0};
      if (r[w]) r = r ^ full;
      if (i < w && b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // coefficient k of prod_{i<npar}(x + alpha^i)
  function automatic logic [15:0] gen_coef(int npar, int k, int w, logic [15:0] poly);
    logic [15:0] g [33];
    logic [15:0] root;
    for (int j = 0; j < 33; j++) g[j] = '0;
    g[0] = 16'd1;
    root = 16'd1;
    for (int i = 0; i < npar; i++) begin
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul_w(g[j], root, w, poly);
      g[0] = gf_mul_w(g[0], root, w, poly);
      root = gf_mul_w(root, 16'd2, w, poly);
    end
    return g[k];
  endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul #(
  parameter int          SYM_W = 10,
  parameter logic [15:0] POLY  = 16'h0009,
  parameter logic [15:0] CONST = 16'h0001
) (
  input  logic [SYM_W-1:0] a_i,
  output logic [SYM_W-1:0] p_o
);
  import rs_ecc_pkg::*;

  logic [SYM_W-1:0] term [SYM_W];

  for (genvar j = 0; j < SYM_W; j++) begin : g_col
    localparam logic [15:0] COL = gf_mul_w(CONST, 16'd1 << j, SYM_W, POLY);
    assign term[j] = a_i[j] ? COL[SYM_W-1:0] : '0;
  end

  always_comb begin
    p_o = '0;
    for (int j = 0; j < SYM_W; j++) p_o = p_o ^ term[j];
  end
endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
  parameter int          SYM_W = 10,
  parameter int          NPAR  = 8,
  parameter logic [15:0] POLY  = 16'h0009
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  shift_i,
  input  logic [SYM_W-1:0]      sym_i,
  output logic [NPAR*SYM_W-1:0] par_o
);
  import rs_ecc_pkg::*;

  logic [SYM_W-1:0] q_q  [NPAR];
  logic [SYM_W-1:0] prod [NPAR];
  logic [SYM_W-1:0] fb;

  assign fb = sym_i ^ q_q[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_tap
    localparam logic [15:0] GK = gen_coef(NPAR, k, SYM_W, POLY);
    rs_gf_cmul #(.SYM_W(SYM_W), .POLY(POLY), .CONST(GK)) u_mul (
      .a_i(fb),
      .p_o(prod[k])
    );
    assign par_o[k*SYM_W +: SYM_W] = q_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q[k] <= '0;
      else if (clr_i)   q_q[k] <= '0;
      else if (shift_i) begin
        if (k == 0) q_q[k] <= prod[k];
        else        q_q[k] <= q_q[(k == 0) ? 0 : k-1] ^ prod[k];
      end
    end
  end

  assert_clr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (par_o == '0));
endmodule

// File: rtl/rs_par_emit.sv
module rs_par_emit #(
  parameter int SYM_W = 10,
  parameter int NPAR  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  go_i,
  input  logic [NPAR*SYM_W-1:0] par_i,
  output logic                  valid_o,
  output logic [SYM_W-1:0]      sym_o,
  output logic                  done_o,
  output logic                  last_o
);
  localparam int IDX_W = (NPAR > 1) ? $clog2(NPAR) : 1;

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [SYM_W-1:0] words [NPAR];

  for (genvar k = 0; k < NPAR; k++) begin : g_word
    assign words[k] = par_i[(NPAR-1-k)*SYM_W +: SYM_W];
  end

  assign valid_o = active_q;
  assign sym_o   = words[idx_q];
  assign done_o  = active_q && (idx_q == '0);
  assign last_o  = active_q && (idx_q == IDX_W'(NPAR-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      active_q <= !last_o;
      idx_q    <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_emit_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
endmodule

// File: rtl/rs_ecc_enc.sv
module rs_ecc_enc #(
  parameter int          DATA_W  = 8,
  parameter int          SYM_W   = 10,
  parameter int          NPAR    = 8,
  parameter int          PKT_LEN = 512,
  parameter logic [15:0] POLY    = 16'h0009
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  data_valid_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic                  data_ready_o,
  output logic                  par_valid_o,
  output logic [SYM_W-1:0]      par_sym_o,
  output logic                  done_o,
  output logic [NPAR*SYM_W-1:0] par_bytes_o
);
  import rs_ecc_pkg::*;

  localparam int CNT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  enc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, last_acc, emit_last;
  logic [SYM_W-1:0] sym_in;

  assign sym_in       = {{(SYM_W-DATA_W){1'b0}}, data_i};
  assign data_ready_o = (state_q == ST_ACCEPT) && !start_i;
  assign accept       = data_valid_i && data_ready_o;
  assign last_acc     = accept && (cnt_q == CNT_W'(PKT_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACCEPT;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ACCEPT;
      cnt_q   <= '0;
    end else begin
      if (accept) cnt_q <= last_acc ? '0 : cnt_q + 1'b1;
      case (state_q)
        ST_ACCEPT: if (last_acc)  state_q <= ST_EMIT;
        ST_EMIT:   if (emit_last) state_q <= ST_HOLD;
        default:   state_q <= ST_HOLD;
      endcase
    end
  end

  rs_lfsr #(.SYM_W(SYM_W), .NPAR(NPAR), .POLY(POLY)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .shift_i(accept),
    .sym_i  (sym_in),
    .par_o  (par_bytes_o)
  );

  rs_par_emit #(.SYM_W(SYM_W), .NPAR(NPAR)) u_emit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .go_i   (last_acc),
    .par_i  (par_bytes_o),
    .valid_o(par_valid_o),
    .sym_o  (par_sym_o),
    .done_o (done_o),
    .last_o (emit_last)
  );

  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_ready_o && !start_i) |=> $stable(par_bytes_o));
  assert_ready_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_ready_o && par_valid_o));
  assert_last_to_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_acc && !start_i) |=> done_o);
endmodule

// File: tb/rs_ecc_enc_tb_top.sv
module rs_ecc_enc_tb_top;
  localparam int NB = 512;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dvalid = 1'b0;
  logic [7:0]  din = '0;
  logic        dready, pvalid, done;
  logic [9:0]  psym;
  logic [79:0] pbytes;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] pkt [NB];
  logic [9:0] cw  [NB+NP];
  logic [9:0] gpl [NP+1];
  logic [9:0] exp_par [NP];
  logic [9:0] got_par [NP];

  always #10 clk = ~clk;

  rs_ecc_enc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_valid_i(dvalid),
    .data_i(din), .data_ready_o(dready), .par_valid_o(pvalid), .par_sym_o(psym),
    .done_o(done), .par_bytes_o(pbytes)
  );

  function automatic logic [9:0] gmul(logic [9:0] a, logic [9:0] b);
    logic [9:0] r = '0;
    logic [9:0] x = a;
    for (int i = 0; i < 10; i++) begin
      if (b[i]) r = r ^ x;
      x = x[9] ? ({x[8:0], 1'b0} ^ 10'h009) : {x[8:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic build_gen();
    logic [9:0] root = 10'd1;
    for (int j = 0; j <= NP; j++) gpl[j] = '0;
    gpl[0] = 10'd1;
    for (int r = 0; r < NP; r++) begin
      for (int j = r + 1; j >= 1; j--) gpl[j] = gpl[j-1] ^ gmul(gpl[j], root);
      gpl[0] = gmul(gpl[0], root);
      root = gmul(root, 10'd2);
    end
  endtask

  // long division of d(x)x^8 by g(x); R1 symbol mapping, R2 remainder
  task automatic model();
    logic [9:0] c [NB+NP];
    logic [9:0] q;
    for (int i = 0; i < NB; i++) c[i] = {2'b00, pkt[i]};
    for (int i = NB; i < NB + NP; i++) c[i] = '0;
    for (int i = 0; i < NB; i++) begin
      q = c[i];
      for (int j = 1; j <= NP; j++) c[i+j] = c[i+j] ^ gmul(q, gpl[NP-j]);
    end
    for (int k = 0; k < NP; k++) exp_par[k] = c[NB+k];
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    dvalid = 1'b1; din = b;
    #1 chk(dready, "R7 ready during packet", {79'd0, dready}, 80'd1);
    @(posedge clk);
    #2 dvalid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #2 start = 1'b0;
  endtask

  task automatic run_packet(input string name, input int gap);
    logic [79:0] expb;
    logic [9:0]  s, a;
    for (int i = 0; i < NB; i++) begin
      if (gap != 0 && (i % gap) == gap - 1) @(negedge clk);
      put(pkt[i]);
    end
    model();
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      chk(pvalid, "R4 par_valid", {79'd0, pvalid}, 80'd1);
      chk(done == (k == 0), "R5 done timing", {79'd0, done}, {79'd0, k == 0});
      got_par[k] = psym;
      chk(psym == exp_par[k], "R2 R4 parity symbol", {70'd0, psym}, {70'd0, exp_par[k]});
    end
    @(negedge clk);
    chk(!pvalid && !done, "R4 valid ends", {78'd0, pvalid, done}, 80'd0);
    chk(!dready, "R7 ready low after packet", {79'd0, dready}, 80'd0);
    for (int k = 0; k < NP; k++) expb[79-10*k -: 10] = exp_par[k];
    chk(pbytes == expb, "R6 packed bytes", pbytes, expb);
    chk(pbytes[79:72] == exp_par[0][9:2], "R6 byte 0", {72'd0, pbytes[79:72]}, {72'd0, exp_par[0][9:2]});
    for (int i = 0; i < NB; i++) cw[i] = {2'b00, pkt[i]};
    for (int k = 0; k < NP; k++) cw[NB+k] = got_par[k];
    a = 10'd1;
    for (int r = 0; r < NP; r++) begin
      s = '0;
      for (int n = 0; n < NB + NP; n++) s = gmul(s, a) ^ cw[n];
      chk(s == 0, "R3 syndrome", {70'd0, s}, 80'd0);
      a = gmul(a, 10'd2);
    end
    $display("packet %s checked", name);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dready, "R10 ready", {79'd0, dready}, 80'd1);
    chk(!pvalid && !done, "R10 valid/done", {78'd0, pvalid, done}, 80'd0);
    chk(pbytes == 0, "R10 parity", pbytes, 80'd0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < NB; i++) pkt[i] = 8'h00;
    run_packet("zero", 0);
  endtask

  task automatic t_ramp();
    pulse_start();
    for (int i = 0; i < NB; i++) pkt[i] = 8'(i);
    run_packet("ramp", 0);
  endtask

  task automatic t_ignore();
    logic [79:0] held = pbytes;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      dvalid = 1'b1; din = 8'hFF;
      #1 chk(!dready, "R7 offer refused", {79'd0, dready}, 80'd0);
      @(posedge clk);
      #2 dvalid = 1'b0;
    end
    @(negedge clk);
    chk(pbytes == held, "R7 parity unchanged", pbytes, held);
    chk(!pvalid, "R7 no output", {79'd0, pvalid}, 80'd0);
  endtask

  task automatic t_rand_gaps();
    logic [15:0] lf = 16'hACE1;
    pulse_start();
    @(negedge clk);
    chk(pbytes == 0, "R8 start clears", pbytes, 80'd0);
    chk(dready, "R8 ready after start", {79'd0, dready}, 80'd1);
    for (int i = 0; i < NB; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pkt[i] = lf[7:0];
    end
    run_packet("random", 7);
  endtask

  task automatic t_restart();
    pulse_start();
    for (int i = 0; i < 100; i++) put(8'h5A ^ 8'(i));
    @(negedge clk);
    start = 1'b1; dvalid = 1'b1; din = 8'h77;
    #1 chk(!dready, "R9 start beats byte", {79'd0, dready}, 80'd0);
    @(posedge clk);
    #2 begin start = 1'b0; dvalid = 1'b0; end
    @(negedge clk);
    chk(pbytes == 0, "R8 mid-packet clear", pbytes, 80'd0);
    for (int i = 0; i < NB; i++) pkt[i] = 8'hFF ^ 8'(i * 3);
    run_packet("restart", 0);
  endtask

  initial begin
    build_gen();
    #35 rst_n = 1'b1;
    t_reset();
    t_zero();
    t_ramp();
    t_ignore();
    t_rand_gaps();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule